// File: doc/BRIEF.md
# Shared Timer and Watchdog Prescaler

This block holds an 8-bit event timer, an 8-bit watchdog counter and one power-of-two divider that only one of them can use at a time. Both counters see the same tick source, a one-cycle strobe sampled on the rising clock edge. A configuration register picks which consumer owns the divider and how many ticks it swallows. The consumer that does not own the divider advances on every tick.

Software reaches the block through a single write port. A select bit picks the configuration register or the timer register. The timer keeps a sticky wrap flag. The watchdog fires a one-cycle timeout when it wraps, unless a clear strobe keeps resetting it. All state changes on the rising clock edge, reset is synchronous and active high, and every output comes from a register.

The rate field means something different for each owner. The timer gets ratios of 1:2 to 1:256. The watchdog gets ratios of 1:1 to 1:128.

Top module: `shared_prescaler`

## Requirements
- R1: While `rst` is high, the timer value, wrap flag and timeout all go to 0. The configuration goes to owner = timer with rate = 0.
- R2: A write with `wr_sel` = 0 loads the configuration. Bit 3 is the owner (0 = timer, 1 = watchdog) and bits 2:0 are the rate. Bits 7:4 are ignored. The new setting applies to ticks from the next cycle on.
- R3: When the timer owns the divider, the timer advances once every 2^(rate+1) ticks.
- R4: When the watchdog owns the divider, the timer advances on every tick.
- R5: When the watchdog owns the divider, the watchdog advances once every 2^rate ticks. Otherwise it advances on every tick.
- R6: A write with `wr_sel` = 1 loads `wr_data` into the timer. This load takes priority over a tick in the same cycle.
- R7: `tmr_ovf` is set the cycle after the timer steps from 0xFF to 0x00. It stays set until a timer write clears it.
- R8: A timer write restarts the divider count only when the timer owns the divider.
- R9: `wdt_kick` clears the watchdog count. When the watchdog owns the divider, it also restarts the divider count.
- R10: `wdt_timeout` is high for exactly one cycle, the cycle after the watchdog count steps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Count event strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = configuration, 1 = timer |
| wr_data | input | 8 | Write data |
| wdt_kick | input | 1 | Watchdog clear strobe |
| tmr_value | output | 8 | Current timer count |
| tmr_ovf | output | 1 | Sticky timer wrap flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The assertions assume that `tick_in`, `wr_en` and `wdt_kick` are clean one-cycle-sampled levels with no X. They also assume that a write and a tick may arrive in the same cycle, and that no timer write reaches the block while reset is high. The stimulus changes every input only on the falling edge and keeps every input at 0 during reset. It mixes random ticks, writes and kicks with directed runs. The directed runs force timer and watchdog wraps, writes that land on the same cycle as a tick, and owner changes in the middle of a count.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    OWNER_TIMER = 1'b0,
    OWNER_WDT   = 1'b1
  } sp_owner_e;
endpackage

// File: rtl/sp_cfg_reg.sv
module sp_cfg_reg #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic [RATE_W:0]   wr_bits,
  output sp_pkg::sp_owner_e owner,
  output logic [RATE_W-1:0] rate
);
  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= sp_pkg::OWNER_TIMER;
      rate  <= '0;
    end else if (wr_cfg) begin
      owner <= sp_pkg::sp_owner_e'(wr_bits[RATE_W]);
      rate  <= wr_bits[RATE_W-1:0];
    end
  end
endmodule

// File: rtl/sp_divider.sv
module sp_divider #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr,
  input  logic              to_wdt,
  input  logic [RATE_W-1:0] rate,
  output logic              div_tick
);
  localparam int PRE_W = 1 << RATE_W;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;
  logic [RATE_W:0]  span;

  // Timer owner divides by 2^(rate+1), watchdog owner by 2^rate.
  assign span = {1'b0, rate} + {{RATE_W{1'b0}}, ~to_wdt};

  genvar i;
  generate
    for (i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = span > (RATE_W + 1)'(i);
    end
  endgenerate

  assign div_tick = tick & ((pre_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)
      pre_cnt <= '0;
    else if (tick)
      pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/sp_wrap_counter.sv
module sp_wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap_evt
);
  assign wrap_evt = inc & ~clr & ~load & (&count);

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (inc)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
  parameter int TMR_W  = 8,
  parameter int WDT_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             wdt_kick,
  output logic [TMR_W-1:0] tmr_value,
  output logic             tmr_ovf,
  output logic             wdt_timeout
);
  sp_pkg::sp_owner_e owner;
  logic [RATE_W-1:0] rate;
  logic              owner_wdt;
  logic              wr_cfg, wr_tmr;
  logic              div_tick, div_clr;
  logic              tmr_inc, wdt_inc;
  logic              tmr_wrap, wdt_wrap;
  logic [WDT_W-1:0]  wdt_count;

  assign wr_cfg    = wr_en & ~wr_sel;
  assign wr_tmr    = wr_en & wr_sel;
  assign owner_wdt = (owner == sp_pkg::OWNER_WDT);
  assign div_clr   = owner_wdt ? wdt_kick : wr_tmr;
  assign tmr_inc   = owner_wdt ? tick_in : div_tick;
  assign wdt_inc   = owner_wdt ? div_tick : tick_in;

  sp_cfg_reg #(.RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_bits(wr_data[RATE_W:0]),
    .owner(owner), .rate(rate)
  );

  sp_divider #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .tick(tick_in), .clr(div_clr),
    .to_wdt(owner_wdt), .rate(rate), .div_tick(div_tick)
  );

  sp_wrap_counter #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(1'b0), .load(wr_tmr), .load_val(wr_data),
    .inc(tmr_inc), .count(tmr_value), .wrap_evt(tmr_wrap)
  );

  sp_wrap_counter #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst(rst), .clr(wdt_kick), .load(1'b0), .load_val('0),
    .inc(wdt_inc), .count(wdt_count), .wrap_evt(wdt_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_ovf     <= 1'b0;
      wdt_timeout <= 1'b0;
    end else begin
      wdt_timeout <= wdt_wrap;
      if (wr_tmr)
        tmr_ovf <= 1'b0;
      else if (tmr_wrap)
        tmr_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_in,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [TMR_W-1:0] wr_data,
  input logic             wdt_kick,
  input logic             owner_wdt,
  input logic [TMR_W-1:0] tmr_value,
  input logic             tmr_ovf,
  input logic             wdt_timeout
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (tmr_value == '0 && !tmr_ovf && !wdt_timeout));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick_in && !(wr_en && wr_sel)) |=> $stable(tmr_value));

  p_every_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (owner_wdt && tick_in && !(wr_en && wr_sel)) |=>
      tmr_value == TMR_W'($past(tmr_value) + 1'b1));

  p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> tmr_value == $past(wr_data));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (tmr_ovf && !(wr_en && wr_sel)) |=> tmr_ovf);

  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> !tmr_ovf);

  p_kick_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    wdt_kick |=> !wdt_timeout);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !wdt_timeout);
endmodule

bind shared_prescaler sp_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .wdt_kick(wdt_kick), .owner_wdt(owner_wdt),
  .tmr_value(tmr_value), .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
);

// File: tb/shared_prescaler_test.sv
module shared_prescaler_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, wdt_kick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] tmr_value;
  logic       tmr_ovf, wdt_timeout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_owner, m_rate, m_pre, m_tmr, m_ovf, m_wdt, m_to;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_prescaler uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wdt_kick(wdt_kick), .tmr_value(tmr_value),
    .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
  );

  function automatic int ratio_of(int owner, int rate);
    return (owner != 0) ? (1 << rate) : (2 << rate);
  endfunction

  function automatic void model_reset();
    m_owner = 0; m_rate = 0; m_pre = 0; m_tmr = 0; m_ovf = 0; m_wdt = 0; m_to = 0;
  endfunction

  function automatic void model_step(bit t, bit we, bit ws, int d, bit k);
    int  r    = ratio_of(m_owner, m_rate);
    bit  fire = t && ((m_pre % r) == r - 1);
    bit  twr  = we && ws;
    bit  t_up = (m_owner != 0) ? t : fire;
    bit  w_up = (m_owner != 0) ? fire : t;
    if ((twr && m_owner == 0) || (k && m_owner != 0)) m_pre = 0;
    else if (t) m_pre = (m_pre + 1) % 256;
    if (twr) begin
      m_tmr = d; m_ovf = 0;
    end else if (t_up) begin
      if (m_tmr == 255) m_ovf = 1;
      m_tmr = (m_tmr + 1) % 256;
    end
    m_to = 0;
    if (k) m_wdt = 0;
    else if (w_up) begin
      if (m_wdt == 255) begin m_to = 1; m_wdt = 0; end
      else m_wdt++;
    end
    if (we && !ws) begin
      m_owner = (d >> 3) & 1; m_rate = d & 7;
    end
  endfunction

  task automatic compare(string tag);
    checks++;
    if (tmr_value !== 8'(m_tmr)) begin
      errors++;
      $display("FAIL %s timer actual %0d expected %0d", tag, tmr_value, m_tmr);
    end
    checks++;
    if (tmr_ovf !== 1'(m_ovf)) begin
      errors++;
      $display("FAIL %s R7 ovf actual %0d expected %0d", tag, tmr_ovf, m_ovf);
    end
    checks++;
    if (wdt_timeout !== 1'(m_to)) begin
      errors++;
      $display("FAIL %s R10 timeout actual %0d expected %0d", tag, wdt_timeout, m_to);
    end
  endtask

  task automatic step(bit t, bit we, bit ws, int d, bit k, string tag);
    tick_in = t; wr_en = we; wr_sel = ws; wr_data = 8'(d); wdt_kick = k;
    model_step(t, we, ws, d, k);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1");

    // R3: timer owns divider, rate 2 -> 1:8
    step(0, 1, 0, 8'h02, 0, "R2");
    ticks(17, "R3");
    // R2: upper bits ignored, owner watchdog, rate 1
    step(0, 1, 0, 8'hF9, 0, "R2");
    ticks(5, "R4");
    // R6: load and tick in same cycle
    step(1, 1, 1, 8'h40, 0, "R6");
    // R7: wrap, sticky, clear
    step(0, 1, 1, 8'hFE, 0, "R7");
    ticks(4, "R7");
    step(0, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 8'h10, 0, "R7");
    // R5 and R10: watchdog owner rate 1 -> 512 ticks to timeout
    step(0, 0, 0, 0, 1, "R9");
    ticks(515, "R5");
    // R8: timer write in watchdog-owned mode keeps divider phase
    step(1, 0, 0, 0, 0, "R8");
    step(0, 1, 1, 8'h00, 0, "R8");
    ticks(3, "R8");
    // R8: timer owner rate 3, partial count then timer write restarts
    step(0, 1, 0, 8'h03, 0, "R2");
    ticks(5, "R8");
    step(0, 1, 1, 8'h00, 0, "R8");
    ticks(17, "R8");
    // R5 and R10: timer owner, watchdog every tick
    step(0, 0, 0, 0, 1, "R9");
    ticks(260, "R10");
    // R9: kick just before wrap suppresses timeout
    ticks(250, "R9");
    step(1, 0, 0, 0, 1, "R9");
    ticks(10, "R9");

    // random mix with fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 20000; i++) begin
      int  sel = $urandom_range(0, 99);
      bit  t   = $urandom_range(0, 3) != 0;
      bit  we  = sel < 4;
      bit  ws  = $urandom_range(0, 1);
      int  d   = $urandom_range(0, 255);
      bit  k   = sel >= 98;
      step(t, we, ws, d, k, m_owner != 0 ? "R4" : "R3");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule